// File: doc/BRIEF.md
# Timed Serial Frame Master for a Multi-Channel Converter Port

This block is the host side of a three-wire write port: an active-low frame strobe, a serial clock and a data line. A client hands it one channel word through a valid/ready handshake. The word is a 5-bit channel address and a 14-bit code. The block then builds the whole waveform from the system clock. The serial clock rests low. The data line changes only as the serial clock rises, so the receiver can take each bit on the falling edge. Every phase lasts a fixed number of system clock cycles, and those counts are set by parameters. A check at elaboration compares each count with the minimum timing limits for the given clock period. Those limits are: the high and low time of the serial clock, its maximum rate, the lead from the strobe falling to the first falling edge, the data setup and hold times, and the quiet time after a frame.

The frame carries the address first, most significant bit first, and then the code, most significant bit first. That makes 19 serial clocks. An optional padded mode is chosen for each word. It stretches the frame to 24 clocks, as if three byte transfers were sent. The 19 valid bits lead and five zero bits follow, and the receiver discards them. After the last falling edge the strobe stays low for a hold period and then rises. The block then waits a long inter-frame gap before it offers ready again, so a busy client cannot break the minimum spacing between frames.

The sequencer has six states. IDLE waits for a word. LEAD holds the strobe low with the first bit on the line. HIGH is the serial clock high phase. LOW is the clock low phase between bits. TRAIL holds the strobe low after the last falling edge. GAP keeps the strobe high until the quiet time has passed.

The transitions are:
- IDLE goes to LEAD when a word is accepted.
- LEAD goes to HIGH when its count ends.
- HIGH goes to LOW while more bits remain.
- HIGH goes to TRAIL after the final bit.
- LOW goes to HIGH, and the next bit is shifted out at that step.
- TRAIL goes to GAP.
- GAP goes to IDLE.

Top module: `sfm_frame_master`

## Requirements
- R1: After reset, and whenever no word is accepted, `sync_n` is 1, `sclk` is 0, `sdo` is 0 and `in_ready` is 1.
- R2: A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. `sync_n` is 0 in the very next cycle. `in_ready` stays 0 from then until the frame and its gap have ended. `in_addr`, `in_code` and `pad24` are captured at acceptance, and later changes to them have no effect on the frame.
- R3: The serial bits are `in_addr[4]` down to `in_addr[0]`, then `in_code[13]` down to `in_code[0]`. Each bit is the value of `sdo` while `sclk` is high before a falling edge. `sdo` changes only in the cycle where `sclk` rises.
- R4: A frame has 19 falling `sclk` edges when `pad24` is 0 and 24 when `pad24` is 1. In the 24-edge case the last five bits are 0.
- R5: Every `sclk` high phase lasts exactly HI_CYC cycles. Every low phase between two bits lasts exactly LO_CYC cycles.
- R6: `sync_n` is 0 with `sclk` low for exactly LEAD_CYC cycles before the first rising `sclk` edge.
- R7: After the last falling edge, `sync_n` stays 0 for LO_CYC cycles. It is then 1 for exactly GAP_CYC cycles with `in_ready` 0 before `in_ready` returns to 1.
- R8: `sclk` is never 1 while `sync_n` is 1, and `sdo` is 0 whenever `sync_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | Block can accept a word (IDLE) |
| in_addr | input | ADDR_W | Channel address |
| in_code | input | CODE_W | Channel code |
| pad24 | input | 1 | 1 selects the padded 24-clock frame |
| sync_n | output | 1 | Active-low frame strobe |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data, changes on rising sclk |

## Verification
Assertions check several rules on every cycle:
- Ready and the strobe never overlap.
- The serial clock is only high inside a frame.
- Data changes only on a rising serial clock.
- Each high phase has its exact length.
- No frame starts before the quiet time since the last falling edge.
- Each frame ends with 19 or 24 falling edges.

Only the bench scenarios can show the rest. They confirm the bit order and content for every address and for corner codes in both frame modes. They also confirm that input changes after acceptance are ignored, and they measure the exact lead, low-phase, trail and gap cycle counts.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TRAIL,
        ST_GAP
    } sfm_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sfm_timer.sv
module sfm_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] value,
    output logic          done
);
    logic [TW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= value;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign done = (remain == '0);

endmodule

// File: rtl/sfm_shifter.sv
module sfm_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word <= '0;
        else if (load)
            word <= value;
        else if (shift)
            word <= {word[W-2:0], 1'b0};
    end

    assign msb = word[W-1];

endmodule

// File: rtl/sfm_frame_master.sv
module sfm_frame_master
    import sfm_pkg::*;
#(
    parameter int ADDR_W          = 5,
    parameter int CODE_W          = 14,
    parameter int PAD_LEN         = 24,
    parameter int CLK_PS          = 4000,
    parameter int HI_CYC          = 5,
    parameter int LO_CYC          = 5,
    parameter int LEAD_CYC        = 2,
    parameter int GAP_CYC         = 50,
    parameter int SCLK_MIN_PER_PS = 33334,
    parameter int PHASE_MIN_PS    = 13000,
    parameter int LEAD_MIN_PS     = 15000,
    parameter int SETUP_MIN_PS    = 10000,
    parameter int HOLD_MIN_PS     = 5000,
    parameter int GAP_MIN_PS      = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [CODE_W-1:0] in_code,
    input  logic              pad24,
    output logic              sync_n,
    output logic              sclk,
    output logic              sdo
);
    localparam int WORD_LEN = ADDR_W + CODE_W;
    localparam int BC_W     = $clog2(PAD_LEN + 1);
    localparam int TMR_MAX  = max_of(max_of(HI_CYC, LO_CYC), max_of(LEAD_CYC, GAP_CYC));
    localparam int TW       = $clog2(TMR_MAX) + 1;

    localparam logic [TW-1:0]   T_LEAD = TW'(LEAD_CYC - 1);
    localparam logic [TW-1:0]   T_HI   = TW'(HI_CYC - 1);
    localparam logic [TW-1:0]   T_LO   = TW'(LO_CYC - 1);
    localparam logic [TW-1:0]   T_GAP  = TW'(GAP_CYC - 1);
    localparam logic [BC_W-1:0] N_WORD = BC_W'(WORD_LEN);
    localparam logic [BC_W-1:0] N_PAD  = BC_W'(PAD_LEN);

    // Elaboration-time parameter checks against the timing limits
    initial begin
        a_prm_period : assert ((HI_CYC + LO_CYC) * CLK_PS >= SCLK_MIN_PER_PS)
            else $error("serial clock period too short");
        a_prm_high   : assert (HI_CYC * CLK_PS >= max_of(PHASE_MIN_PS, SETUP_MIN_PS))
            else $error("high phase too short for width or setup");
        a_prm_low    : assert (LO_CYC * CLK_PS >= max_of(PHASE_MIN_PS, HOLD_MIN_PS))
            else $error("low phase too short for width or hold");
        a_prm_lead   : assert ((LEAD_CYC + HI_CYC) * CLK_PS >= LEAD_MIN_PS && LEAD_CYC >= 1)
            else $error("lead time too short");
        a_prm_gap    : assert (GAP_CYC * CLK_PS >= GAP_MIN_PS)
            else $error("inter-frame gap too short");
        a_prm_pad    : assert (PAD_LEN > WORD_LEN)
            else $error("pad length must exceed word length");
    end

    sfm_state_e      state, nstate;
    logic            tmr_load, tmr_done;
    logic [TW-1:0]   tmr_val;
    logic            sh_load, sh_shift, sh_msb;
    logic [BC_W-1:0] bits_left;
    logic [PAD_LEN-1:0] sh_value;

    assign sh_value = PAD_LEN'({in_addr, in_code}) << (PAD_LEN - WORD_LEN);

    sfm_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .value (tmr_val),
        .done  (tmr_done)
    );

    sfm_shifter #(.W(PAD_LEN)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .value (sh_value),
        .shift (sh_shift),
        .msb   (sh_msb)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nstate;
    end

    // Bit counter: loaded at acceptance, decremented at each falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bits_left <= '0;
        else if (sh_load)
            bits_left <= pad24 ? N_PAD : N_WORD;
        else if (state == ST_HIGH && tmr_done)
            bits_left <= bits_left - 1'b1;
    end

    // Next state and phase timer control
    always_comb begin
        nstate   = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state)
            ST_IDLE: if (in_valid) begin
                nstate   = ST_LEAD;
                tmr_load = 1'b1;
                tmr_val  = T_LEAD;
                sh_load  = 1'b1;
            end
            ST_LEAD: if (tmr_done) begin
                nstate   = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = T_HI;
            end
            ST_HIGH: if (tmr_done) begin
                nstate   = (bits_left == BC_W'(1)) ? ST_TRAIL : ST_LOW;
                tmr_load = 1'b1;
                tmr_val  = T_LO;
            end
            ST_LOW: if (tmr_done) begin
                nstate   = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = T_HI;
                sh_shift = 1'b1;
            end
            ST_TRAIL: if (tmr_done) begin
                nstate   = ST_GAP;
                tmr_load = 1'b1;
                tmr_val  = T_GAP;
            end
            ST_GAP: if (tmr_done) begin
                nstate = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // Outputs decoded from registered state
    always_comb begin
        in_ready = (state == ST_IDLE);
        sclk     = (state == ST_HIGH);
        sync_n   = !(state == ST_LEAD || state == ST_HIGH ||
                     state == ST_LOW  || state == ST_TRAIL);
        sdo      = sync_n ? 1'b0 : sh_msb;
    end

    // Checker state for the assertions below
    logic [TW-1:0]   hi_run;
    logic [TW:0]     since_fall;
    logic [BC_W-1:0] fall_cnt;
    logic            sclk_d;
    localparam logic [TW-1:0] HI_L  = TW'(HI_CYC);
    localparam logic [TW:0]   GAP_L = (TW + 1)'(GAP_CYC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run     <= '0;
            since_fall <= GAP_L;
            fall_cnt   <= '0;
            sclk_d     <= 1'b0;
        end else begin
            sclk_d     <= sclk;
            hi_run     <= sclk ? hi_run + 1'b1 : '0;
            if (sclk)
                since_fall <= '0;
            else if (since_fall < GAP_L)
                since_fall <= since_fall + 1'b1;
            fall_cnt   <= sync_n ? '0 : fall_cnt + BC_W'(sclk_d & ~sclk);
        end
    end

    a_r2_accept_starts_frame : assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !sync_n);
    a_r2_busy_not_ready : assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |-> !in_ready);
    a_r3_sdo_moves_on_rise : assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n && $past(!sync_n) && !$rose(sclk)) |-> $stable(sdo));
    a_r4_edge_count : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> (fall_cnt == N_WORD || fall_cnt == N_PAD));
    a_r5_high_width : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_run == HI_L));
    a_r7_gap_before_sync : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_n) |-> (since_fall >= GAP_L));
    a_r8_sclk_inside_frame : assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !sync_n);
    a_r8_sdo_quiet_idle : assert property (@(posedge clk) disable iff (!rst_n)
        sync_n |-> !sdo);

endmodule

// File: tb/tb_sfm_frame_master.sv
`timescale 1ns/1ps
module tb_sfm_frame_master;

    localparam int HI_CYC   = 5;
    localparam int LO_CYC   = 5;
    localparam int LEAD_CYC = 2;
    localparam int GAP_CYC  = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [4:0]  in_addr = '0;
    logic [13:0] in_code = '0;
    logic        pad24 = 1'b0;
    logic        sync_n, sclk, sdo;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sfm_frame_master #(
        .HI_CYC(HI_CYC), .LO_CYC(LO_CYC), .LEAD_CYC(LEAD_CYC), .GAP_CYC(GAP_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_code(in_code), .pad24(pad24),
        .sync_n(sync_n), .sclk(sclk), .sdo(sdo)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sends one word, scrambles the inputs after acceptance, decodes the waveform
    task automatic send_frame(input logic [4:0] a, input logic [13:0] c, input logic pad);
        int lead = -1, lowrun = 0, hirun = 0, trail = -1, gap = 0, nfall = 0, nrise = 0;
        int hi_bad = 0, lo_bad = 0, v8 = 0, v2 = 0, guard = 0;
        logic prev_sclk = 1'b0, prev_sdo = 1'b0;
        logic [31:0] got = '0;
        logic [31:0] exp_word;
        int nb;
        nb       = pad ? 24 : 19;
        exp_word = pad ? 32'({a, c, 5'b0}) : 32'({a, c});
        in_valid = 1'b1; in_addr = a; in_code = c; pad24 = pad;
        @(negedge clk);
        in_valid = 1'b0; in_addr = ~a; in_code = ~c; pad24 = ~pad;
        chk(sync_n == 1'b0, "R2 sync after accept", sync_n, 0);
        chk(in_ready == 1'b0, "R2 ready drops", in_ready, 0);
        while (!in_ready && guard < 2000) begin
            guard++;
            if (sync_n && (sclk || sdo)) v8++;
            if (!sync_n && in_ready) v2++;
            if (sync_n) begin
                if (trail < 0) trail = lowrun;
                gap++;
            end else if (sclk) begin
                if (!prev_sclk) begin
                    if (nrise == 0) lead = lowrun;
                    else if (lowrun != LO_CYC) lo_bad++;
                    nrise++;
                    hirun = 1;
                end else hirun++;
            end else begin
                if (prev_sclk) begin
                    got = {got[30:0], prev_sdo};
                    nfall++;
                    if (hirun != HI_CYC) hi_bad++;
                    lowrun = 1;
                end else lowrun++;
            end
            prev_sclk = sclk;
            prev_sdo  = sdo;
            @(negedge clk);
        end
        chk(nfall == nb, "R4 falling edge count", nfall, nb);
        chk(got == exp_word, "R3 R4 bit content", got, exp_word);
        chk(lead == LEAD_CYC, "R6 lead cycles", lead, LEAD_CYC);
        chk(hi_bad == 0, "R5 high phase width", hi_bad, 0);
        chk(lo_bad == 0, "R5 low phase width", lo_bad, 0);
        chk(trail == LO_CYC, "R7 trail cycles", trail, LO_CYC);
        chk(gap == GAP_CYC, "R7 gap cycles", gap, GAP_CYC);
        chk(v8 == 0, "R8 idle sclk sdo", v8, 0);
        chk(v2 == 0, "R2 ready in frame", v2, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sync_n == 1'b1, "R1 reset sync_n", sync_n, 1);
        chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
        chk(sdo == 1'b0, "R1 reset sdo", sdo, 0);
        chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
        rst_n = 1'b1;
        // R1: idle without a word
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(sync_n && !sclk && !sdo && in_ready, "R1 idle hold",
                {sync_n, sclk, sdo, in_ready}, 4'b1001);
        end
        // Sweep every address, both frame modes, varied codes
        for (int a = 0; a < 32; a++) begin
            send_frame(5'(a), 14'((a * 517 + 3) & 16'h3FFF), 1'(a & 1));
        end
        // Corner codes in both modes
        for (int m = 0; m < 2; m++) begin
            send_frame(5'd0,  14'h0000, 1'(m));
            send_frame(5'd31, 14'h3FFF, 1'(m));
            send_frame(5'd21, 14'h2AAA, 1'(m));
            send_frame(5'd10, 14'h1555, 1'(m));
        end
        @(negedge clk);
        chk(sync_n && in_ready, "R1 idle after frames", {sync_n, in_ready}, 2'b11);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule